// File: doc/BRIEF.md
# Multiword Sticky Right Shifter

This block shifts a wide floating-point mantissa to the right, for example to align two operands before an add or to denormalize a result. The mantissa is 128 bits wide and is stored as four 32-bit words. Word 0 is the most significant word and sits in bits 127:96. Every 1 bit that drops off the low end is ORed into a single sticky flag, so a rounding stage further down the pipe still knows that some precision was lost. The incoming sticky flag is kept: the bits lost in this shift are ORed onto it and never replace it.

The datapath works in two steps. A word-move step first moves whole 32-bit words down by the upper bits of the shift amount. A bit step then shifts by the low five bits, and each word takes its upper neighbour's low bits into its top. A shift amount at or above a parameterised flush limit takes a shortcut: the result is all zero and sticky is set. The result is registered, so a request presented with `in_valid` produces its result one cycle later. The registered output holds its value while no request is presented.

Top module: `msrs_shifter`

## Requirements
- R1: During reset and just after it, `out_valid`, `out_mant` and `out_sticky` are all 0.
- R2: A request accepted on a clock edge (`in_valid` high) appears on the outputs after that edge with `out_valid` high. A cycle without a request leaves `out_valid` low after the next edge.
- R3: With a shift amount at or above `FLUSH_LIMIT` (default 115), `out_mant` is all zero and `out_sticky` is 1, whatever the mantissa.
- R4: With a shift amount from 96 up to the flush limit, the result holds only word 0 (bits 127:96), moved down into the word-3 position and shifted right by the low five bits. Words 1 to 3 are lost into sticky.
- R5: With a shift amount from 64 to 95, words 0 and 1 move down to the word-2 and word-3 positions before the bit step. Words 2 and 3 are lost into sticky.
- R6: With a shift amount from 32 to 63, every word moves down one position, the top word becomes zero, and word 3 is lost into sticky.
- R7: The low five bits of the shift amount (1 to 31) shift within words. Each word takes its upper neighbour's low bits into its top bits, and the bits leaving word 3 are lost into sticky. The overall result equals the 128-bit mantissa shifted right by the shift amount.
- R8: An incoming sticky of 1 always gives `out_sticky` = 1.
- R9: With an incoming sticky of 0, `out_sticky` is 1 exactly when at least one 1 bit was shifted out below bit 0.
- R10: While `in_valid` is low, `out_mant` and `out_sticky` keep the last result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | A request is presented this cycle |
| in_mant | input | 128 | Mantissa, word 0 in bits 127:96 |
| in_sticky | input | 1 | Sticky flag carried in with the mantissa |
| in_shamt | input | 8 | Right shift amount, 1 to 255 |
| out_valid | output | 1 | Registered result is new this cycle |
| out_mant | output | 128 | Shifted mantissa |
| out_sticky | output | 1 | Incoming sticky ORed with all lost bits |

## Verification
The assertions assume that a valid request never carries a shift amount of zero; such a request is illegal and no behaviour is defined for it. The stimulus keeps every shift amount between 1 and 255. It covers the edges of each word band (31, 32, 63, 64, 95, 96), the edge just below and at the flush limit, and amounts far beyond it. Mantissas are chosen so that the lost bits are sometimes all zero and sometimes a single 1 at bit 0, so the sticky decision is tested at its edge.

// File: rtl/msrs_pkg.sv
package msrs_pkg;

    // Default geometry: four 32-bit words, most significant word first
    localparam int DEF_WORD_W  = 32;
    localparam int DEF_WORDS   = 4;
    localparam int DEF_SHAMT_W = 8;
    localparam int DEF_FLUSH   = 115;

    // Path the top module selects for a request
    typedef enum logic [1:0] {
        ROUTE_IDLE  = 2'd0,
        ROUTE_SHIFT = 2'd1,
        ROUTE_FLUSH = 2'd2
    } route_e;

endpackage

// File: rtl/msrs_word_stage.sv
module msrs_word_stage #(
    parameter int WORD_W    = 32,
    parameter int NUM_WORDS = 4,
    parameter int WSH_W     = 3
) (
    input  logic [NUM_WORDS-1:0][WORD_W-1:0] mant_in,
    input  logic [WSH_W-1:0]                 wsh,
    output logic [NUM_WORDS-1:0][WORD_W-1:0] mant_out,
    output logic                             lost_any
);
    // Packed index p: 0 is the least significant word
    logic [WORD_W-1:0] dropped;

    always_comb begin
        mant_out = '0;
        dropped  = '0;
        for (int p = 0; p < NUM_WORDS; p++) begin
            if (p + int'(wsh) < NUM_WORDS) begin
                mant_out[p] = mant_in[p + int'(wsh)];
            end
            if (p < int'(wsh)) begin
                dropped = dropped | mant_in[p];
            end
        end
        lost_any = |dropped;
    end

    // When no word moves, nothing may be reported as lost
    always_comb begin
        if (wsh == '0) begin
            AST_WORD_NOLOSS_AT_ZERO: assert (!lost_any); // R6
        end
    end

endmodule

// File: rtl/msrs_bit_stage.sv
module msrs_bit_stage #(
    parameter int WORD_W    = 32,
    parameter int NUM_WORDS = 4,
    parameter int BSH_W     = 5
) (
    input  logic [NUM_WORDS-1:0][WORD_W-1:0] mant_in,
    input  logic [BSH_W-1:0]                 bsh,
    output logic [NUM_WORDS-1:0][WORD_W-1:0] mant_out,
    output logic                             lost_any
);
    logic [WORD_W-1:0] tail;

    genvar p;
    generate
        for (p = 0; p < NUM_WORDS; p++) begin : g_word
            logic [WORD_W-1:0] upper;
            if (p == NUM_WORDS - 1) begin : g_top
                assign upper = '0;
            end else begin : g_mid
                assign upper = mant_in[p + 1];
            end
            // A shift by WORD_W yields zero, so bsh == 0 brings in nothing
            assign mant_out[p] = (mant_in[p] >> bsh)
                               | (upper << (WORD_W - int'(bsh)));
        end
    endgenerate

    assign tail     = mant_in[0] << (WORD_W - int'(bsh));
    assign lost_any = |tail;

    always_comb begin
        if (bsh == '0) begin
            AST_BIT_NOLOSS_AT_ZERO: assert (!lost_any); // R7
        end
    end

endmodule

// File: rtl/msrs_shifter.sv
module msrs_shifter
    import msrs_pkg::*;
#(
    parameter int WORD_W      = DEF_WORD_W,
    parameter int NUM_WORDS   = DEF_WORDS,
    parameter int SHAMT_W     = DEF_SHAMT_W,
    parameter int FLUSH_LIMIT = DEF_FLUSH,
    localparam int MANT_W     = WORD_W * NUM_WORDS,
    localparam int BSH_W      = $clog2(WORD_W),
    localparam int WSH_W      = SHAMT_W - BSH_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [MANT_W-1:0] in_mant,
    input  logic              in_sticky,
    input  logic [SHAMT_W-1:0] in_shamt,
    output logic              out_valid,
    output logic [MANT_W-1:0] out_mant,
    output logic              out_sticky
);
    typedef struct packed {
        logic              valid;
        logic [MANT_W-1:0] mant;
        logic              sticky;
    } state_t;

    state_t state_d, state_q;
    route_e route_d;

    logic [NUM_WORDS-1:0][WORD_W-1:0] words_in, words_mid, words_out;
    logic [WSH_W-1:0] wsh;
    logic [BSH_W-1:0] bsh;
    logic word_lost, bit_lost;

    assign words_in = in_mant;
    assign wsh      = in_shamt[SHAMT_W-1:BSH_W];
    assign bsh      = in_shamt[BSH_W-1:0];

    msrs_word_stage #(
        .WORD_W    (WORD_W),
        .NUM_WORDS (NUM_WORDS),
        .WSH_W     (WSH_W)
    ) u_word (
        .mant_in  (words_in),
        .wsh      (wsh),
        .mant_out (words_mid),
        .lost_any (word_lost)
    );

    msrs_bit_stage #(
        .WORD_W    (WORD_W),
        .NUM_WORDS (NUM_WORDS),
        .BSH_W     (BSH_W)
    ) u_bit (
        .mant_in  (words_mid),
        .bsh      (bsh),
        .mant_out (words_out),
        .lost_any (bit_lost)
    );

    always_comb begin
        state_d = state_q;
        if (!in_valid) begin
            route_d = ROUTE_IDLE;
        end else if (int'(in_shamt) >= FLUSH_LIMIT) begin
            route_d = ROUTE_FLUSH;
        end else begin
            route_d = ROUTE_SHIFT;
        end

        unique case (route_d)
            ROUTE_FLUSH: begin
                state_d.valid  = 1'b1;
                state_d.mant   = '0;
                state_d.sticky = 1'b1;
            end
            ROUTE_SHIFT: begin
                state_d.valid  = 1'b1;
                state_d.mant   = words_out;
                state_d.sticky = in_sticky | word_lost | bit_lost;
            end
            default: begin
                state_d.valid  = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign out_valid  = state_q.valid;
    assign out_mant   = state_q.mant;
    assign out_sticky = state_q.sticky;

    // Input assumption: a valid request never asks for a zero shift
    AST_SHAMT_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |-> in_shamt != '0); // R7
    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid); // R2
    AST_IDLE_NO_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid); // R2
    AST_FLUSH_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && int'(in_shamt) >= FLUSH_LIMIT) |=> (out_mant == '0 && out_sticky)); // R3
    AST_STICKY_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_sticky) |=> out_sticky); // R8
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(out_mant) && $stable(out_sticky))); // R10

endmodule

// File: tb/msrs_shifter_bench.sv
module msrs_shifter_bench;
    localparam int CLK_PERIOD = 10;
    localparam int FLUSH      = 115;
    localparam int WATCHDOG   = 20000;

    typedef struct {
        logic [127:0] mant;
        logic         sticky;
        string        tag;
    } exp_t;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic [127:0] in_mant = '0;
    logic         in_sticky = 1'b0;
    logic [7:0]   in_shamt = 8'd1;
    logic         out_valid;
    logic [127:0] out_mant;
    logic         out_sticky;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    exp_t sb_q[$];
    exp_t last_exp;

    always #(CLK_PERIOD/2) clk = ~clk;

    msrs_shifter u_msrs_shifter (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .in_mant    (in_mant),
        .in_sticky  (in_sticky),
        .in_shamt   (in_shamt),
        .out_valid  (out_valid),
        .out_mant   (out_mant),
        .out_sticky (out_sticky)
    );

    function automatic exp_t model(logic [127:0] m, logic s, int sh, string tag);
        exp_t e;
        logic [127:0] mask;
        e.tag = tag;
        if (sh >= FLUSH) begin
            e.mant   = '0;
            e.sticky = 1'b1;
        end else begin
            mask     = (128'd1 << sh) - 128'd1;
            e.mant   = m >> sh;
            e.sticky = s | ((m & mask) != '0);
        end
        return e;
    endfunction

    task automatic send(logic [127:0] m, logic s, int sh, string tag);
        @(negedge clk);
        in_valid  = 1'b1;
        in_mant   = m;
        in_sticky = s;
        in_shamt  = 8'(sh);
        sb_q.push_back(model(m, s, sh, tag));
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    // Monitor: one comparison per result, sampled on the falling edge
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            exp_t e;
            if (sb_q.size() == 0) begin
                fails++;
                $display("FAIL R2: unexpected result, actual valid=1 expected valid=0");
            end else begin
                e = sb_q.pop_front();
                last_exp = e;
                checks++;
                if (out_mant !== e.mant || out_sticky !== e.sticky) begin
                    fails++;
                    $display("FAIL %s: actual mant=%h sticky=%b expected mant=%h sticky=%b",
                             e.tag, out_mant, out_sticky, e.mant, e.sticky);
                end
            end
        end
    end

    task automatic check_idle_hold(string tag);
        repeat (3) @(negedge clk);
        checks++;
        if (out_valid !== 1'b0 || out_mant !== last_exp.mant || out_sticky !== last_exp.sticky) begin
            fails++;
            $display("FAIL %s: actual valid=%b mant=%h sticky=%b expected valid=0 mant=%h sticky=%b",
                     tag, out_valid, out_mant, out_sticky, last_exp.mant, last_exp.sticky);
        end
    endtask

    localparam logic [127:0] PAT_A = 128'h8000_0001_F00D_CAFE_1234_5678_9ABC_DEF1;
    localparam logic [127:0] PAT_B = 128'hFFFF_0000_0000_0000_0000_0000_0000_0000;

    initial begin : drive
        repeat (3) @(negedge clk);
        // R1: reset state
        checks++;
        if (out_valid !== 1'b0 || out_mant !== '0 || out_sticky !== 1'b0) begin
            fails++;
            $display("FAIL R1: actual valid=%b mant=%h sticky=%b expected all zero",
                     out_valid, out_mant, out_sticky);
        end
        rst_n = 1'b1;
        @(negedge clk);
        checks++;
        if (out_valid !== 1'b0 || out_mant !== '0 || out_sticky !== 1'b0) begin
            fails++;
            $display("FAIL R1: after release actual valid=%b mant=%h sticky=%b expected all zero",
                     out_valid, out_mant, out_sticky);
        end

        send(PAT_A, 1'b0, 4,   "R7");
        send(PAT_A, 1'b0, 31,  "R7");
        send(PAT_A, 1'b0, 32,  "R6");
        send(PAT_A, 1'b0, 45,  "R6");
        send(PAT_A, 1'b0, 63,  "R6");
        send(PAT_A, 1'b0, 64,  "R5");
        send(PAT_A, 1'b0, 77,  "R5");
        send(PAT_A, 1'b0, 95,  "R5");
        send(PAT_A, 1'b0, 96,  "R4");
        send(PAT_A, 1'b0, 114, "R4");
        send(PAT_A, 1'b0, 115, "R3");
        send(128'd0, 1'b0, 200, "R3");
        send(PAT_A, 1'b0, 255, "R3");
        check_idle_hold("R10");
        check_idle_hold("R2");
        // Sticky edges: lost bits all zero vs. a single 1 at bit 0
        send(PAT_B, 1'b0, 100, "R9");
        send(PAT_B, 1'b1, 100, "R8");
        send(128'd1, 1'b0, 1,  "R9");
        send(128'd1 << 40, 1'b0, 40, "R9");
        send(128'd1 << 40, 1'b0, 41, "R9");
        send(PAT_B, 1'b1, 8,   "R8");
        // Back-to-back requests
        @(negedge clk);
        for (int i = 0; i < 60; i++) begin
            logic [127:0] m;
            int sh;
            m  = {$urandom, $urandom, $urandom, $urandom};
            if (i % 3 == 0) m = m & (128'hFFFF_FFFF << (32 * (i % 4)));
            sh = 1 + ($urandom % 130);
            in_valid  = 1'b1;
            in_mant   = m;
            in_sticky = 1'(i % 5 == 0);
            in_shamt  = 8'(sh);
            sb_q.push_back(model(m, 1'(i % 5 == 0), sh, "R7"));
            @(negedge clk);
        end
        in_valid = 1'b0;
        repeat (2) @(negedge clk);
        check_idle_hold("R10");
        checks++;
        if (sb_q.size() != 0) begin
            fails++;
            $display("FAIL R2: actual pending=%0d expected pending=0", sb_q.size());
        end
        done = 1'b1;
    end

    initial begin : watchdog
        int cyc = 0;
        while (!done && cyc < WATCHDOG) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            fails++;
            $display("FAIL R2: watchdog expired, actual cycles=%0d expected completion", cyc);
        end
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule